// File: doc/BRIEF.md
# Memory-to-Memory Byte Processor Core

A small multicycle processor whose every instruction works on memory bytes named by direct 8-bit addresses. Code and data share one 256-byte synchronous single-port RAM that sits next to the core. The core has no immediate operands, no general registers that a program can see, and no indirect addressing. It fetches an opcode byte and then its address operands into hidden latches. It reads the source bytes, computes, and writes the result back to memory. A program builds a pointer by writing an address into the operand byte of a later instruction.

Two timing features protect the core from memory that is not ready. After reset the core stays idle for `STARTUP_CYC` cycles, because block RAM can read as all zeros just after configuration. The default of 48 cycles suits a 12 MHz clock. After each read request the core waits `WAIT_CYC` cycles before it uses the returned byte. An illegal opcode or a HALT parks the core until reset.

Top module: `mm8_core`

## Requirements
- R1: After reset release the core makes no memory access during cycles 0 to STARTUP_CYC-1. Its first access is an opcode read of address 0x00 in cycle STARTUP_CYC.
- R2: The core makes at most one access per cycle. After a read request in cycle t it makes no access in cycles t+1 to t+WAIT_CYC, and it uses the read data presented in cycle t+WAIT_CYC.
- R3: Opcodes 0x01 (ADD), 0x02 (SUB), 0x03 (AND) and 0x04 (OR) take four bytes: opcode, dst, a, b. The core writes mem[dst] = mem[a] op mem[b], modulo 256. SUB computes a minus b.
- R4: Opcode 0x05 (COPY) takes three bytes: opcode, dst, src. The core writes mem[dst] = mem[src].
- R5: Opcode 0x06 (JMP) takes two bytes: opcode, target. The next opcode is fetched from target.
- R6: Opcode 0x07 (JZ) takes three bytes: opcode, target, src. If mem[src] is zero, the next opcode comes from target. Otherwise it comes from the byte after src.
- R7: Opcode 0x00 (NOP) is one byte long. It makes one read and no write.
- R8: Opcode 0xFF (HALT) raises halted_o. From then on halted_o stays high and the core makes no memory access until reset.
- R9: Any opcode value not listed in R3 to R8 halts the core in the same way as R8. No later instruction has any effect.
- R10: The program counter wraps modulo 256, both between instructions and between the bytes of one instruction.
- R11: A byte written by an instruction is seen by every later fetch of that address, so code can modify its own operands.
- R12: While rst_ni is low, halted_o, mem_rd_o and mem_wr_o are low. Reset from the halted state starts a new hold-off and runs again from address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | RAM address for a read or a write |
| mem_rd_o | output | 1 | Read request; the data is used WAIT_CYC cycles later |
| mem_wr_o | output | 1 | Write strobe; the RAM writes on the clock edge |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data from the RAM |
| halted_o | output | 1 | Core is stopped on HALT or an illegal opcode |

## Verification
A corrupt opcode, operand latch or program counter shows up within one instruction. It appears as a write to the wrong address, a result byte with the wrong value, or a fetch from the wrong place that soon reaches an illegal byte and raises halted_o. The memory model in the bench drives a garbage byte on every cycle except the exact data cycle. It also returns zeros during the start-up window. An error in the wait counter or the hold-off therefore turns into wrong results or an early halt within a few dozen cycles. Access-spacing errors are seen on the cycle they happen, as a request inside a wait window or a read and write in the same cycle.

// File: rtl/mm8_pkg.sv
package mm8_pkg;

  localparam int unsigned WORD_W = 8;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t OPC_NOP  = 8'h00;
  localparam word_t OPC_ADD  = 8'h01;
  localparam word_t OPC_SUB  = 8'h02;
  localparam word_t OPC_AND  = 8'h03;
  localparam word_t OPC_OR   = 8'h04;
  localparam word_t OPC_COPY = 8'h05;
  localparam word_t OPC_JMP  = 8'h06;
  localparam word_t OPC_JZ   = 8'h07;
  localparam word_t OPC_HALT = 8'hFF;

  typedef enum logic [2:0] {
    ST_BOOT, ST_RD, ST_WAIT, ST_DEC, ST_EXEC, ST_WB, ST_HALT
  } state_e;

  // destination of the byte being read
  typedef enum logic [1:0] {TG_OPC, TG_ARG, TG_OPA, TG_OPB} tgt_e;

  typedef enum logic [2:0] {K_NOP, K_ALU, K_COPY, K_JMP, K_JZ, K_STOP} kind_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] n_args;
    alu_op_e    alu_op;
  } dec_t;

endpackage

// File: rtl/mm8_decode.sv
module mm8_decode
  import mm8_pkg::*;
(
  input  logic [WORD_W-1:0] opc_i,
  output dec_t              dec_o
);

  always_comb begin
    dec_o = '{kind: K_STOP, n_args: 2'd0, alu_op: ALU_ADD};
    unique case (opc_i)
      OPC_NOP:  dec_o.kind = K_NOP;
      OPC_ADD:  dec_o = '{kind: K_ALU, n_args: 2'd3, alu_op: ALU_ADD};
      OPC_SUB:  dec_o = '{kind: K_ALU, n_args: 2'd3, alu_op: ALU_SUB};
      OPC_AND:  dec_o = '{kind: K_ALU, n_args: 2'd3, alu_op: ALU_AND};
      OPC_OR:   dec_o = '{kind: K_ALU, n_args: 2'd3, alu_op: ALU_OR};
      OPC_COPY: dec_o = '{kind: K_COPY, n_args: 2'd2, alu_op: ALU_ADD};
      OPC_JMP:  dec_o = '{kind: K_JMP, n_args: 2'd1, alu_op: ALU_ADD};
      OPC_JZ:   dec_o = '{kind: K_JZ, n_args: 2'd2, alu_op: ALU_ADD};
      default:  dec_o.kind = K_STOP; // HALT and every unlisted value
    endcase
  end

endmodule

// File: rtl/mm8_alu.sv
module mm8_alu
  import mm8_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [WORD_W-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      default: y_o = a_i | b_i;
    endcase
  end

endmodule

// File: rtl/mm8_holdoff.sv
module mm8_holdoff #(
  parameter int unsigned CYC = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);

  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // ready during the last idle cycle, so the first read lands in cycle CYC
  assign ready_o = (cnt_q == LAST);

endmodule

// File: rtl/mm8_wait_timer.sv
module mm8_wait_timer #(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);

  localparam int unsigned CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(WAIT_CYC - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/mm8_core.sv
module mm8_core
  import mm8_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 48,
  parameter int unsigned WAIT_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              halted_o
);

  localparam int unsigned MAX_ARGS = 3;

  state_e state_q;
  tgt_e   tgt_q;
  word_t  pc_q, opc_q, rd_addr_q, opa_q, opb_q;
  logic [MAX_ARGS-1:0][WORD_W-1:0] args_q;
  logic [1:0] arg_idx_q;
  dec_t   dec_q, dec_c;
  word_t  alu_y;
  logic   boot_ready, wait_done, last_arg;

  mm8_holdoff #(.CYC(STARTUP_CYC)) u_holdoff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_o (boot_ready)
  );

  mm8_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (state_q == ST_RD),
    .done_o  (wait_done)
  );

  mm8_decode u_dec (
    .opc_i (opc_q),
    .dec_o (dec_c)
  );

  mm8_alu u_alu (
    .a_i  (opa_q),
    .b_i  (opb_q),
    .op_i (dec_q.alu_op),
    .y_o  (alu_y)
  );

  assign last_arg = (arg_idx_q == dec_q.n_args - 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_BOOT;
      tgt_q     <= TG_OPC;
      pc_q      <= '0;
      opc_q     <= '0;
      rd_addr_q <= '0;
      opa_q     <= '0;
      opb_q     <= '0;
      args_q    <= '0;
      arg_idx_q <= '0;
      dec_q     <= '0;
    end else begin
      unique case (state_q)
        ST_BOOT: begin
          if (boot_ready) begin
            rd_addr_q <= pc_q;
            tgt_q     <= TG_OPC;
            state_q   <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (wait_done) begin
            unique case (tgt_q)
              TG_OPC: begin
                opc_q   <= mem_rdata_i;
                pc_q    <= pc_q + 1'b1;
                state_q <= ST_DEC;
              end
              TG_ARG: begin
                args_q[arg_idx_q] <= mem_rdata_i;
                pc_q      <= pc_q + 1'b1;
                arg_idx_q <= arg_idx_q + 1'b1;
                if (last_arg) begin
                  state_q <= ST_EXEC;
                end else begin
                  rd_addr_q <= pc_q + 1'b1;
                  state_q   <= ST_RD;
                end
              end
              TG_OPA: begin
                opa_q <= mem_rdata_i;
                if (dec_q.kind == K_ALU) begin
                  rd_addr_q <= args_q[2];
                  tgt_q     <= TG_OPB;
                  state_q   <= ST_RD;
                end else begin
                  state_q <= ST_WB;
                end
              end
              default: begin
                opb_q   <= mem_rdata_i;
                state_q <= ST_WB;
              end
            endcase
          end
        end
        ST_DEC: begin
          dec_q     <= dec_c;
          arg_idx_q <= '0;
          unique case (dec_c.kind)
            K_NOP: begin
              rd_addr_q <= pc_q;
              tgt_q     <= TG_OPC;
              state_q   <= ST_RD;
            end
            K_STOP: state_q <= ST_HALT;
            default: begin
              rd_addr_q <= pc_q;
              tgt_q     <= TG_ARG;
              state_q   <= ST_RD;
            end
          endcase
        end
        ST_EXEC: begin
          state_q <= ST_RD;
          if (dec_q.kind == K_JMP) begin
            pc_q      <= args_q[0];
            rd_addr_q <= args_q[0];
            tgt_q     <= TG_OPC;
          end else begin
            rd_addr_q <= args_q[1];
            tgt_q     <= TG_OPA;
          end
        end
        ST_WB: begin
          tgt_q   <= TG_OPC;
          state_q <= ST_RD;
          if (dec_q.kind == K_JZ && opa_q == '0) begin
            pc_q      <= args_q[0];
            rd_addr_q <= args_q[0];
          end else begin
            rd_addr_q <= pc_q;
          end
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    mem_rd_o    = (state_q == ST_RD);
    mem_wr_o    = (state_q == ST_WB) && (dec_q.kind == K_ALU || dec_q.kind == K_COPY);
    mem_addr_o  = (state_q == ST_WB) ? args_q[0] : rd_addr_q;
    mem_wdata_o = (dec_q.kind == K_COPY) ? opa_q : alu_y;
    halted_o    = (state_q == ST_HALT);
  end

endmodule

// File: rtl/mm8_core_chk.sv
module mm8_core_chk #(
  parameter int unsigned STARTUP_CYC = 48,
  parameter int unsigned WAIT_CYC    = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_rd_i,
  input logic       mem_wr_i,
  input logic [7:0] mem_addr_i,
  input logic       halted_i
);

  localparam int unsigned BW = $clog2(STARTUP_CYC + 1);
  localparam int unsigned GW = $clog2(WAIT_CYC + 1);

  logic [BW-1:0] boot_cnt_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          boot_cnt_q <= '0;
    else if (boot_cnt_q != BW'(STARTUP_CYC)) boot_cnt_q <= boot_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= '0;
    else if (mem_rd_i)      gap_q <= GW'(WAIT_CYC);
    else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
  end

  p_holdoff_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_cnt_q < BW'(STARTUP_CYC)) |-> (!mem_rd_i && !mem_wr_i));

  p_first_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_cnt_q == BW'(STARTUP_CYC - 1)) |=> (mem_rd_i && mem_addr_i == 8'h00));

  p_wait_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q != '0) |-> (!mem_rd_i && !mem_wr_i));

  p_one_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_i && mem_wr_i));

  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  p_halt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> (!mem_rd_i && !mem_wr_i));

endmodule

bind mm8_core mm8_core_chk #(
  .STARTUP_CYC (STARTUP_CYC),
  .WAIT_CYC    (WAIT_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_rd_i   (mem_rd_o),
  .mem_wr_i   (mem_wr_o),
  .mem_addr_i (mem_addr_o),
  .halted_i   (halted_o)
);

// File: tb/mm8_core_tb_top.sv
module mm8_core_tb_top;

  localparam int STARTUP = 20;
  localparam int WAITC   = 3;
  localparam int LAT     = 3;
  localparam int READY   = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_rd, mem_wr, halted;

  always #10 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;

  logic [7:0] img [256];
  logic [7:0] ram [256];
  logic [LAT-1:0]       pv, pz;
  logic [LAT-1:0][7:0]  pa;
  int ram_cyc;

  // RAM model: data valid only in the LAT-th cycle after a request, zero before READY
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) ram[i] <= img[i];
      pv <= '0;
      pz <= '0;
      pa <= '0;
      ram_cyc <= 0;
    end else begin
      if (mem_wr) ram[mem_addr] <= mem_wdata;
      pv <= {pv[LAT-2:0], mem_rd};
      pz <= {pz[LAT-2:0], (ram_cyc < READY)};
      pa <= {pa[LAT-2:0], mem_addr};
      ram_cyc <= ram_cyc + 1;
    end
  end

  assign mem_rdata = pv[LAT-1] ? (pz[LAT-1] ? 8'h00 : ram[pa[LAT-1]]) : 8'hA5;

  mm8_core #(.STARTUP_CYC(STARTUP), .WAIT_CYC(WAITC)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .halted_o    (halted)
  );

  int first_rd, first_addr, rd_cnt, wr_cnt, gap_bad, halted_seen, quiet_bad;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  task automatic put(input int a, input logic [7:0] v);
    img[a] = v;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R12 halted_o in reset", int'(halted), 0);
    check("R12 rd/wr in reset", int'(mem_rd | mem_wr), 0);
  endtask

  task automatic run_prog(input int max_cyc);
    int gap;
    first_rd = -1; first_addr = -1; rd_cnt = 0; wr_cnt = 0;
    gap_bad = 0; halted_seen = 0; quiet_bad = 0; gap = 0;
    rst_ni = 1'b1;
    for (int k = 0; k < max_cyc; k++) begin
      if (mem_rd) begin
        rd_cnt++;
        if (first_rd < 0) begin first_rd = k; first_addr = int'(mem_addr); end
      end
      if (mem_wr) wr_cnt++;
      if (gap > 0 && (mem_rd || mem_wr)) gap_bad++;
      if (mem_rd && mem_wr) gap_bad++;
      gap = mem_rd ? WAITC : ((gap > 0) ? gap - 1 : 0);
      if (halted) begin halted_seen = 1; break; end
      @(negedge clk_i);
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (mem_rd || mem_wr || !halted) quiet_bad++;
    end
  endtask

  task automatic test_alu();
    clear_img();
    put(8'h40, 8'h30); put(8'h41, 8'hE5); put(8'h42, 8'h0F); put(8'h43, 8'hF0);
    put(8'h00, 8'h01); put(8'h01, 8'h50); put(8'h02, 8'h40); put(8'h03, 8'h41);
    put(8'h04, 8'h02); put(8'h05, 8'h51); put(8'h06, 8'h40); put(8'h07, 8'h41);
    put(8'h08, 8'h03); put(8'h09, 8'h52); put(8'h0A, 8'h41); put(8'h0B, 8'h42);
    put(8'h0C, 8'h04); put(8'h0D, 8'h53); put(8'h0E, 8'h42); put(8'h0F, 8'h43);
    put(8'h10, 8'hFF);
    do_reset();
    run_prog(4000);
    check("R1 first read cycle", first_rd, STARTUP);
    check("R1 first read address", first_addr, 0);
    check("R2 access spacing", gap_bad, 0);
    check("R3 ADD wraps", int'(ram[8'h50]), 8'h15);
    check("R3 SUB a-b", int'(ram[8'h51]), 8'h4B);
    check("R3 AND", int'(ram[8'h52]), 8'h05);
    check("R3 OR", int'(ram[8'h53]), 8'hFF);
    check("R8 halted after HALT", halted_seen, 1);
  endtask

  task automatic test_copy_ptr();
    clear_img();
    put(8'h60, 8'h70); put(8'h70, 8'h3C);
    put(8'h00, 8'h05); put(8'h01, 8'h08); put(8'h02, 8'h60);
    put(8'h06, 8'h05); put(8'h07, 8'h61); put(8'h08, 8'h00);
    put(8'h09, 8'hFF);
    do_reset();
    run_prog(4000);
    check("R4 COPY result", int'(ram[8'h08]), 8'h70);
    check("R11 patched operand used", int'(ram[8'h61]), 8'h3C);
    check("R2 access spacing copy", gap_bad, 0);
  endtask

  task automatic test_jumps();
    clear_img();
    put(8'h90, 8'h77); put(8'h91, 8'h00); put(8'h92, 8'h01);
    put(8'h00, 8'h06); put(8'h01, 8'h10);
    put(8'h02, 8'h05); put(8'h03, 8'h80); put(8'h04, 8'h90);
    put(8'h10, 8'h07); put(8'h11, 8'h20); put(8'h12, 8'h92);
    put(8'h13, 8'h05); put(8'h14, 8'h81); put(8'h15, 8'h90);
    put(8'h16, 8'h07); put(8'h17, 8'h30); put(8'h18, 8'h91);
    put(8'h19, 8'h05); put(8'h1A, 8'h82); put(8'h1B, 8'h90);
    put(8'h1C, 8'hFF);
    put(8'h20, 8'h05); put(8'h21, 8'h83); put(8'h22, 8'h90); put(8'h23, 8'hFF);
    put(8'h30, 8'h05); put(8'h31, 8'h84); put(8'h32, 8'h90); put(8'h33, 8'hFF);
    do_reset();
    run_prog(4000);
    check("R5 JMP skips", int'(ram[8'h80]), 0);
    check("R6 JZ not taken falls through", int'(ram[8'h81]), 8'h77);
    check("R6 JZ not taken target untouched", int'(ram[8'h83]), 0);
    check("R6 JZ taken skips", int'(ram[8'h82]), 0);
    check("R6 JZ taken target runs", int'(ram[8'h84]), 8'h77);
  endtask

  task automatic test_wrap();
    clear_img();
    put(8'hA4, 8'h5A);
    put(8'h00, 8'h06); put(8'h01, 8'h05); put(8'h02, 8'hA3); put(8'h03, 8'hA4);
    put(8'h04, 8'hFF);
    put(8'h05, 8'h06); put(8'h06, 8'hFE);
    put(8'hFE, 8'h05); put(8'hFF, 8'hA2);
    do_reset();
    run_prog(4000);
    check("R10 operand byte wraps to 0x00", int'(ram[8'hA2]), 8'hFE);
    check("R10 next opcode at 0x01", int'(ram[8'hA3]), 8'h5A);
  endtask

  task automatic test_nop();
    clear_img();
    put(8'h0A, 8'hFF);
    do_reset();
    run_prog(4000);
    check("R7 NOP makes no write", wr_cnt, 0);
    check("R7 one read per NOP plus HALT", rd_cnt, 11);
    check("R8 quiet and sticky after HALT", quiet_bad, 0);
  endtask

  task automatic test_illegal();
    clear_img();
    put(8'h81, 8'h99);
    put(8'h01, 8'h42);
    put(8'h02, 8'h05); put(8'h03, 8'h80); put(8'h04, 8'h81);
    do_reset();
    run_prog(4000);
    check("R9 illegal opcode halts", halted_seen, 1);
    check("R9 later COPY has no effect", int'(ram[8'h80]), 0);
    check("R9 no write", wr_cnt, 0);
    check("R9 quiet while halted", quiet_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_img();
    test_alu();
    test_copy_ptr();
    test_jumps();
    test_wrap();
    test_nop();
    test_illegal();
    test_alu(); // R12: rerun after a halt restarts from 0x00 with a fresh hold-off
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule